// File: doc/BRIEF.md
# Serial Flash Buffered Page-Program Sequencer

This block runs one complete buffered page-program transaction on a four-wire serial flash link: chip select, serial clock, a data line towards the flash and a data line back from it. User logic asks for a transaction with a one-cycle start strobe. The request carries a buffer select and a 24-bit target address that combines the page number with the starting byte offset inside the buffer. The block then sends a program opcode picked by the buffer, the three address bytes and a stream of payload bytes. The payload bytes arrive over a valid/ready handshake, and a last flag marks the final one.

When the final payload byte has been shifted out, the block releases chip select so the flash can start its self-timed program cycle. It then keeps reading the flash status byte, releasing chip select and waiting a programmable gap between reads, until bit 7 of the status shows ready. A timeout limit can be set to cover the worst-case programming time. The block signals the end with a one-cycle done pulse. If the limit runs out first, it also raises a timeout flag.

A parameter sets the number of page buffers to one or two. With a single buffer, a request for the second buffer is refused and no bus activity takes place.

Top module: `flash_prog_seq`

## Requirements
- R1: The first byte sent is 0x82 when `buf_sel` is 0 and 0x85 when `buf_sel` is 1.
- R2: With `DUAL_BUF` = 0, a start with `buf_sel` = 1 produces a one-cycle `reject_err` pulse in the following cycle. `busy` stays low and `cs_n` stays high.
- R3: The opcode is followed by `addr[23:16]`, `addr[15:8]` and `addr[7:0]`, in that order. After them come the accepted payload bytes, in acceptance order, with no other bytes in between.
- R4: Every byte is sent most-significant bit first. `mosi` changes only in a cycle where `sck` falls while `cs_n` is low. `cs_n` falls only while `sck` is high, and `sck` is high whenever `cs_n` is high.
- R5: While bits are being shifted, `sck` has a period of `CLK_DIV` system clock cycles.
- R6: If `wr_valid` is low during the payload phase, `cs_n` stays low and `sck` stays high without toggling. The payload phase ends only after the byte flagged by `wr_last` has been sent.
- R7: After the last payload byte, `cs_n` goes high for at least `POLL_GAP` cycles. Each status poll is then one chip-select period carrying exactly the bytes 0xD7 and 0x00, and the status is taken from the bits returned during the second byte. A gap of at least `POLL_GAP` cycles with `cs_n` high separates consecutive polls.
- R8: Polling stops at the first status byte whose bit 7 is 1. `done` then pulses for one cycle, and the number of polls equals the number of busy replies plus one. `busy` is high from the cycle after an accepted start through the done cycle, and low in the cycle after it.
- R9: If a poll returns bit 7 = 0 after at least `TMO_CYCLES` cycles since chip select rose at the end of the payload, the block stops polling, pulses `done` and sets `timeout_err`. `timeout_err` stays high until the next accepted start. After a successful completion, `timeout_err` is 0.
- R10: After reset, `cs_n` = 1, `sck` = 1, `busy` = 0, `done` = 0, `wr_ready` = 0, `timeout_err` = 0 and `reject_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, accepted when idle |
| buf_sel | input | 1 | 0 selects the first page buffer, 1 the second |
| addr | input | 24 | Page and starting byte address, sampled at start |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte is valid |
| wr_last | input | 1 | Marks the final payload byte |
| wr_ready | output | 1 | Block accepts a payload byte this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Ready bit was not seen within the limit |
| reject_err | output | 1 | One-cycle pulse for a refused second-buffer request |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Flash serial clock, idles high |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A flash model on the bench decodes every chip-select period. It replies to status reads with a chosen number of busy answers before it reports ready, or never reports ready. The bench aims at a payload stall in the middle of the data phase. A design that got this wrong would keep toggling the clock, drop chip select, or send a stale byte, and the scoreboard would see an extra or reordered byte. It also tests a single-byte payload, where the first byte is also the last, and a design that waits for a second byte would hang. It checks the opcode of the second buffer and the refusal of that buffer in a one-buffer build. A design that still starts would show chip-select activity. Finally it runs a timeout case. A design that checks the ready bit at the wrong bit position, or does not count polls, would report the wrong number of polls, finish too early, or leave the timeout flag wrong.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_WAIT,
        ST_POLL_OP,
        ST_POLL_RD
    } seq_state_t;

    localparam logic [7:0] OP_PROG_BUF_A = 8'h82;
    localparam logic [7:0] OP_PROG_BUF_B = 8'h85;
    localparam logic [7:0] OP_STATUS_RD  = 8'hD7;
    localparam logic [7:0] FILL_BYTE     = 8'h00;

    typedef struct packed {
        seq_state_t  state;
        logic        busy;
        logic        done;
        logic        tmo_err;
        logic        rej_err;
        logic        cs_n;
        logic [1:0]  hdr_idx;
        logic        last_seen;
        logic [23:0] addr;
    } seq_regs_t;

endpackage

// File: rtl/flash_bit_shifter.sv
module flash_bit_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

    typedef struct packed {
        logic          active;
        logic          sck;
        logic          mosi;
        logic          done;
        logic [2:0]    bit_idx;
        logic [CW-1:0] cnt;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } shift_regs_t;

    shift_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (load) begin
            r_d.active  = 1'b1;
            r_d.sck     = 1'b1;
            r_d.bit_idx = 3'd7;
            r_d.cnt     = HALF_M1;
            r_d.tx      = tx_byte;
        end else if (r_q.active) begin
            if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - 1'b1;
            end else if (r_q.sck) begin
                r_d.sck  = 1'b0;
                r_d.mosi = r_q.tx[r_q.bit_idx];
                r_d.cnt  = HALF_M1;
            end else begin
                r_d.sck = 1'b1;
                r_d.rx  = {r_q.rx[6:0], miso};
                r_d.cnt = HALF_M1;
                if (r_q.bit_idx == 3'd0) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.bit_idx = r_q.bit_idx - 3'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.sck <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck       = r_q.sck;
    assign mosi      = r_q.mosi;
    assign active    = r_q.active;
    assign byte_done = r_q.done;
    assign rx_byte   = r_q.rx;

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int POLL_GAP   = 8,
    parameter int TMO_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic elapsed_clr,
    input  logic gap_load,
    output logic gap_done,
    output logic expired
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int TW = $clog2(TMO_CYCLES + 1);
    localparam logic [GW-1:0] GAP_INIT = GW'(POLL_GAP);
    localparam logic [TW-1:0] TMO_LIM  = TW'(TMO_CYCLES);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [TW-1:0] elapsed;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (gap_load)
            r_d.gap = GAP_INIT;
        else if (r_q.gap != '0)
            r_d.gap = r_q.gap - 1'b1;
        if (elapsed_clr)
            r_d.elapsed = '0;
        else if (r_q.elapsed < TMO_LIM)
            r_d.elapsed = r_q.elapsed + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign gap_done = (r_q.gap == '0);
    assign expired  = (r_q.elapsed >= TMO_LIM);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int DUAL_BUF   = 1,
    parameter int POLL_GAP   = 8,
    parameter int TMO_CYCLES = 1500000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        buf_sel,
    input  logic [23:0] addr,
    input  logic [7:0]  wr_data,
    input  logic        wr_valid,
    input  logic        wr_last,
    output logic        wr_ready,
    output logic        busy,
    output logic        done,
    output logic        timeout_err,
    output logic        reject_err,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam bit HAS_BUF_B = (DUAL_BUF != 0);

    seq_regs_t r_q, r_d;

    logic       sh_load;
    logic [7:0] sh_byte;
    logic       sh_active;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       gap_load;
    logic       elapsed_clr;
    logic       gap_done;
    logic       expired;
    logic       ready_int;

    flash_bit_shifter #(.HALF(HALF)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .tx_byte   (sh_byte),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .active    (sh_active),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    flash_poll_timer #(.POLL_GAP(POLL_GAP), .TMO_CYCLES(TMO_CYCLES)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .elapsed_clr (elapsed_clr),
        .gap_load    (gap_load),
        .gap_done    (gap_done),
        .expired     (expired)
    );

    assign ready_int = (r_q.state == ST_DATA) && !sh_active && !r_q.last_seen;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.rej_err = 1'b0;
        sh_load     = 1'b0;
        sh_byte     = FILL_BYTE;
        gap_load    = 1'b0;
        elapsed_clr = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.done) r_d.busy = 1'b0;
                if (start && !r_q.busy) begin
                    if (buf_sel && !HAS_BUF_B) begin
                        r_d.rej_err = 1'b1;
                    end else begin
                        r_d.busy      = 1'b1;
                        r_d.tmo_err   = 1'b0;
                        r_d.cs_n      = 1'b0;
                        r_d.addr      = addr;
                        r_d.hdr_idx   = 2'd0;
                        r_d.last_seen = 1'b0;
                        r_d.state     = ST_HDR;
                        sh_load       = 1'b1;
                        sh_byte       = buf_sel ? OP_PROG_BUF_B : OP_PROG_BUF_A;
                    end
                end
            end
            ST_HDR: begin
                if (sh_done) begin
                    if (r_q.hdr_idx == 2'd3) begin
                        r_d.state = ST_DATA;
                    end else begin
                        sh_load = 1'b1;
                        unique case (r_q.hdr_idx)
                            2'd0:    sh_byte = r_q.addr[23:16];
                            2'd1:    sh_byte = r_q.addr[15:8];
                            default: sh_byte = r_q.addr[7:0];
                        endcase
                        r_d.hdr_idx = r_q.hdr_idx + 2'd1;
                    end
                end
            end
            ST_DATA: begin
                if (ready_int && wr_valid) begin
                    sh_load       = 1'b1;
                    sh_byte       = wr_data;
                    r_d.last_seen = wr_last;
                end else if (r_q.last_seen && !sh_active) begin
                    r_d.cs_n    = 1'b1;
                    gap_load    = 1'b1;
                    elapsed_clr = 1'b1;
                    r_d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (gap_done) begin
                    r_d.cs_n  = 1'b0;
                    sh_load   = 1'b1;
                    sh_byte   = OP_STATUS_RD;
                    r_d.state = ST_POLL_OP;
                end
            end
            ST_POLL_OP: begin
                if (sh_done) begin
                    sh_load   = 1'b1;
                    sh_byte   = FILL_BYTE;
                    r_d.state = ST_POLL_RD;
                end
            end
            ST_POLL_RD: begin
                if (sh_done) begin
                    r_d.cs_n = 1'b1;
                    if (sh_rx[7]) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else if (expired) begin
                        r_d.done    = 1'b1;
                        r_d.tmo_err = 1'b1;
                        r_d.state   = ST_IDLE;
                    end else begin
                        gap_load  = 1'b1;
                        r_d.state = ST_WAIT;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ready    = ready_int;
    assign busy        = r_q.busy;
    assign done        = r_q.done;
    assign timeout_err = r_q.tmo_err;
    assign reject_err  = r_q.rej_err;
    assign cs_n        = r_q.cs_n;

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic reject_err,
    input logic wr_ready
);
    p_cs_fall_sck_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> sck);

    p_sck_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sck);

    p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$stable(mosi)) |-> $fell(sck));

    p_ready_holds_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!cs_n && sck));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_through_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && cs_n));

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reject_err |-> (!busy && cs_n));

endmodule

bind flash_prog_seq flash_prog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .mosi       (mosi),
    .busy       (busy),
    .done       (done),
    .reject_err (reject_err),
    .wr_ready   (wr_ready)
);

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
    localparam int CLK_DIV = 4;
    localparam int GAP     = 6;
    localparam int TMO     = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start = 1'b0, buf_sel = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0, wr_last = 1'b0;
    logic        wr_ready, busy, done, timeout_err, reject_err, cs_n, sck, mosi;
    logic        miso = 1'b1;

    logic        start_1 = 1'b0;
    logic        wr_ready_1, busy_1, done_1, tmo_1, rej_1, cs_n_1, sck_1, mosi_1;

    flash_prog_seq #(.CLK_DIV(CLK_DIV), .DUAL_BUF(1), .POLL_GAP(GAP), .TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_sel(buf_sel), .addr(addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready),
        .busy(busy), .done(done), .timeout_err(timeout_err), .reject_err(reject_err),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

    flash_prog_seq #(.CLK_DIV(CLK_DIV), .DUAL_BUF(0), .POLL_GAP(GAP), .TMO_CYCLES(TMO)) uut_one (
        .clk(clk), .rst_n(rst_n), .start(start_1), .buf_sel(1'b1), .addr(24'h0),
        .wr_data(8'h00), .wr_valid(1'b0), .wr_last(1'b0), .wr_ready(wr_ready_1),
        .busy(busy_1), .done(done_1), .timeout_err(tmo_1), .reject_err(rej_1),
        .cs_n(cs_n_1), .sck(sck_1), .mosi(mosi_1), .miso(1'b1));

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard
    logic [7:0] exp_q[$];
    int busy_cfg = 0;      // busy replies before ready; 255 = never ready
    int busy_left = 0;
    int poll_cnt = 0;

    // monitor / flash model state
    int   cyc = 0;
    logic prev_sck = 1'b1, prev_cs = 1'b1;
    int   bitcnt = 0;
    logic [7:0] shreg = '0;
    logic [7:0] first_b = '0, second_b = '0;
    int   last_rise = 0;
    int   per_err = 0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) begin
            chk(prev_sck == 1'b1, "R4 cs fall with sck high", prev_sck, 1);
            bitcnt = 0;
            per_err = 0;
        end
        if (!cs_n && !prev_sck && sck) begin
            if ((bitcnt % 8) != 0 && (cyc - last_rise) != CLK_DIV) per_err++;
            last_rise = cyc;
            shreg = {shreg[6:0], mosi};
            bitcnt++;
            if (bitcnt % 8 == 0) begin
                if (bitcnt == 8) first_b = shreg;
                if (bitcnt == 16) second_b = shreg;
                if (first_b != 8'hD7) begin
                    if (exp_q.size() == 0)
                        chk(1'b0, "R3 unexpected byte", shreg, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(shreg == e, "R1/R3 byte order", shreg, e);
                    end
                end
            end
        end
        if (!cs_n && prev_sck && !sck && first_b == 8'hD7 && bitcnt >= 8 && bitcnt < 16) begin
            logic [7:0] st;
            st = (busy_left == 0) ? 8'h80 : 8'h00;
            miso = st[15 - bitcnt];
        end
        if (!prev_cs == 1'b1 && cs_n) begin
            if (first_b == 8'hD7) begin
                chk(bitcnt == 16 && second_b == 8'h00, "R7 poll frame", bitcnt, 16);
                poll_cnt++;
                if (busy_left != 0 && busy_left != 255) busy_left--;
            end else begin
                chk(exp_q.size() == 0 && bitcnt % 8 == 0, "R3 program frame length", exp_q.size(), 0);
                chk(per_err == 0, "R5 sck period", per_err, 0);
                busy_left = busy_cfg;
            end
            first_b = 8'h00;
            miso = 1'b1;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    // cs high gap between frames (R7)
    int hi_run = 0;
    bit in_prog = 1'b0;
    always @(negedge clk) begin
        if (cs_n) hi_run++;
        else begin
            if (in_prog && hi_run > 0 && hi_run < GAP)
                chk(1'b0, "R7 cs high gap", hi_run, GAP);
            hi_run = 0;
        end
    end

    task automatic run_prog(input logic bs, input logic [23:0] a, input int n,
                            input int stall_at, input int busy_n, input bit expect_tmo);
        int  wait_c;
        bit  busy_ok;
        busy_cfg = busy_n;
        poll_cnt = 0;
        exp_q.push_back(bs ? 8'h85 : 8'h82);
        exp_q.push_back(a[23:16]);
        exp_q.push_back(a[15:8]);
        exp_q.push_back(a[7:0]);
        @(negedge clk);
        start = 1'b1; buf_sel = bs; addr = a;
        @(negedge clk);
        start = 1'b0;
        in_prog = 1'b1;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        chk(timeout_err == 1'b0, "R9 timeout flag cleared on start", timeout_err, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(8'h3C + i * 8'h51);
            if (i == stall_at) begin
                while (!wr_ready) @(negedge clk);
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (cs_n !== 1'b0 || sck !== 1'b1) begin
                        chk(1'b0, "R6 stall holds bus", {cs_n, sck}, 2'b01);
                        break;
                    end
                end
                chk(cs_n == 1'b0 && sck == 1'b1, "R6 bus held during stall", {cs_n, sck}, 2'b01);
            end
            exp_q.push_back(d);
            wr_valid = 1'b1; wr_data = d; wr_last = (i == n - 1);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0; wr_last = 1'b0;
        end
        busy_ok = 1'b1;
        wait_c = 0;
        while (!done && wait_c < 20000) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            wait_c++;
        end
        chk(done == 1'b1, "R8 done reached", done, 1);
        chk(busy_ok, "R8 busy held until done", busy_ok, 1);
        chk(timeout_err == expect_tmo, "R9 timeout flag", timeout_err, expect_tmo);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 done single pulse, busy drops", {done, busy}, 0);
        if (expect_tmo) begin
            chk(poll_cnt >= 2, "R9 polling continued until limit", poll_cnt, 2);
            repeat (5) @(negedge clk);
            chk(timeout_err == 1'b1, "R9 timeout flag held", timeout_err, 1);
        end else begin
            chk(poll_cnt == busy_n + 1, "R8 poll count", poll_cnt, busy_n + 1);
        end
        in_prog = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(cs_n == 1 && sck == 1 && busy == 0 && done == 0 && wr_ready == 0 &&
            timeout_err == 0 && reject_err == 0, "R10 reset state",
            {cs_n, sck, busy, done, wr_ready, timeout_err, reject_err}, 7'b1100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_prog(1'b0, 24'h12A5C3, 5, -1, 2, 1'b0);
        run_prog(1'b1, 24'hFF0001, 1, -1, 0, 1'b0);
        run_prog(1'b0, 24'h00F70E, 4, 2, 1, 1'b0);
        run_prog(1'b1, 24'h5A5A5A, 2, -1, 255, 1'b1);
        run_prog(1'b0, 24'h800000, 3, 0, 0, 1'b0);

        // R2: second buffer refused in a one-buffer build
        @(negedge clk);
        start_1 = 1'b1;
        @(negedge clk);
        start_1 = 1'b0;
        chk(rej_1 == 1'b1 && busy_1 == 1'b0, "R2 reject pulse", {rej_1, busy_1}, 2'b10);
        @(negedge clk);
        chk(rej_1 == 1'b0, "R2 reject one cycle", rej_1, 0);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int k = 0; k < 40; k++) begin
                if (cs_n_1 !== 1'b1 || busy_1 !== 1'b0 || done_1 !== 1'b0) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R2 no transaction after reject", quiet, 1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule